// File: doc/BRIEF.md
# Linear Image Sensor Scan Sequencer

This block is the digital timing core of a 256-position linear photodiode array built as two sections of 128 pixels each. A start request on the first section's serial input launches a read-out scan. One token then walks across the pixels, one position per clock. A one-cycle hold pulse marks the moment all sampling paths are frozen, and an integrator-reset window opens at the same time. When the token leaves section 1, that section's serial output carries the start into section 2.

The analog parts are outside this block. Integration, sampling capacitors and the charge amplifier show up only as the two output enables and the active pixel index. After a scan, the sequencer refuses new starts for a configurable number of charge-transfer clocks. Any start that arrives too early is dropped and recorded in a sticky error flag. The block expects the two sections to be chained: SO1 is wired back to the SI2 input.

Top module: `scan_sequencer`

## Requirements
- R1: While rst_n is low at a rising edge, every output in the following cycle is 0: serial outputs, hold, integrator reset, both enables, pixel strobe, pixel index and error flag.
- R2: A start is a rising edge on si1_i: it is sampled high at a clock edge after being sampled low at the previous edge, with the sequencer idle. Call that edge number 1 of the scan. The hold output is high for exactly the cycle after edge 1 and only once per scan.
- R3: integ_rst_o is high in the cycles after edges 1 through 18 of a scan and low from edge 19 on.
- R4: After scan edge k, for k from 1 to 256, pix_valid_o is 1 and pix_idx_o equals k-1. Each scan therefore gives exactly 256 strobes, with the index rising by one each cycle.
- R5: oe1_o is high after edges 1 to 128 and oe2_o after edges 129 to 256. The two enables are never high together, and oe2_o drops at edge 257.
- R6: so1_o is high only in the cycle after edge 128, and so2_o only in the cycle after edge 256. Each is a single-cycle pulse.
- R7: With XFER_CLKS = D, a start sampled at any scan edge from 2 to 257+D is not accepted. A start sampled at edge 258+D is accepted as a new scan.
- R8: A start rising edge that arrives during a scan or during the transfer window sets proto_err_o. The flag stays set until reset.
- R9: If si1_i is held high for many edges, only one scan is launched, and the held level does not set the error flag.
- R10: A reset in the middle of a scan ends it at once: enables, strobes, hold and error return to 0, and the sequencer accepts a fresh start afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| si1_i | input | 1 | Start input of section 1 |
| si2_i | input | 1 | Start input of section 2 (tie to so1_o when chained) |
| so1_o | output | 1 | Section 1 serial output, one-cycle token exit pulse |
| so2_o | output | 1 | Section 2 serial output, end-of-scan pulse |
| hold_o | output | 1 | Global sampling-hold pulse |
| integ_rst_o | output | 1 | Integrator reset window |
| oe1_o | output | 1 | Section 1 analog-output enable |
| oe2_o | output | 1 | Section 2 analog-output enable |
| pix_valid_o | output | 1 | A pixel output is enabled this cycle |
| pix_idx_o | output | $clog2(2*SEC_PIX) | Index of the active pixel |
| proto_err_o | output | 1 | Sticky flag for a start that was ignored |

## Verification
The bench drives the section hand-off at edges 128 and 129. A design with an off-by-one error there would show both enables high at once, a gap in the strobe count, or a repeated index. It probes the transfer window on both sides of its edge: a start at edge 257+D must be refused, and one at 258+D must give a back-to-back scan. A design off by one would accept the first or drop the second. A start held high for hundreds of clocks must not relaunch the scan or raise the error flag, which a design that triggers on the level instead of the edge would do. Finally, a reset partway through a scan must leave no stray token alive in either section.

// File: rtl/scan_pkg.sv
// Package: shared defaults and the controller phase type for the scan
// sequencer. Assumes nothing beyond IEEE 1800-2017.
package scan_pkg;
    localparam int DEF_SEC_PIX   = 128;
    localparam int DEF_RST_CLKS  = 18;
    localparam int DEF_XFER_CLKS = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_XFER = 2'd2
    } scan_phase_e;
endpackage

// File: rtl/scan_ctrl.sv
// Module: scan_ctrl
// Detects start edges, counts scan edges, produces hold and the integrator
// reset window, and enforces the post-scan charge-transfer lockout.
// Assumes: RST_CLKS < 2*SEC_PIX; the scan lasts 2*SEC_PIX+1 edges.
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int SEC_PIX   = DEF_SEC_PIX,
    parameter int RST_CLKS  = DEF_RST_CLKS,
    parameter int XFER_CLKS = DEF_XFER_CLKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic si_i,
    output logic launch_o,
    output logic hold_o,
    output logic integ_rst_o,
    output logic err_o
);
    localparam int SCAN_LEN = 2 * SEC_PIX;
    localparam int CMAX     = (SCAN_LEN > XFER_CLKS) ? SCAN_LEN : XFER_CLKS;
    localparam int CW       = $clog2(CMAX + 1);

    scan_phase_e   phase;
    logic [CW-1:0] cnt;
    logic          si_q;
    logic          rise;

    // Purpose: a start is a sampled low-to-high transition of the start input.
    assign rise     = si_i && !si_q;
    assign launch_o = rise && (phase == PH_IDLE);

    // Purpose: phase sequencing, edge counting and sticky error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            si_q  <= 1'b0;
            err_o <= 1'b0;
        end else begin
            si_q <= si_i;
            if (rise && phase != PH_IDLE) begin
                err_o <= 1'b1;
            end
            unique case (phase)
                PH_IDLE: begin
                    if (rise) begin
                        phase <= PH_SCAN;
                        cnt   <= CW'(1);
                    end
                end
                PH_SCAN: begin
                    if (cnt == CW'(SCAN_LEN)) begin
                        phase <= (XFER_CLKS == 0) ? PH_IDLE : PH_XFER;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                PH_XFER: begin
                    if (int'(cnt) == XFER_CLKS - 1) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // Purpose: decode hold and integrator-reset window from the edge count.
    assign hold_o      = (phase == PH_SCAN) && (cnt == CW'(1));
    assign integ_rst_o = (phase == PH_SCAN) && (cnt <= CW'(RST_CLKS));

    a_r2_hold_single: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> !hold_o);
    a_r3_hold_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> integ_rst_o);
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    a_r7_no_launch_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o);
endmodule

// File: rtl/scan_section.sv
// Module: scan_section
// One section of the token chain: a start sampled while idle places the
// token on the first pixel; it advances one pixel per edge and leaves after
// the last. Assumes SEC_PIX >= 2.
module scan_section #(
    parameter int SEC_PIX = 128,
    localparam int PW     = $clog2(SEC_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          oe_o,
    output logic          so_o,
    output logic [PW-1:0] pos_o
);
    localparam logic [PW-1:0] LAST = PW'(SEC_PIX - 1);

    logic          act;
    logic [PW-1:0] pos;

    // Purpose: load, advance and retire the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            pos <= '0;
        end else if (start_i && !act) begin
            act <= 1'b1;
            pos <= '0;
        end else if (act) begin
            if (pos == LAST) begin
                act <= 1'b0;
                pos <= '0;
            end else begin
                pos <= pos + PW'(1);
            end
        end
    end

    // Purpose: expose enable, exit pulse and position.
    assign oe_o  = act;
    assign so_o  = act && (pos == LAST);
    assign pos_o = pos;

    a_r6_so_single: assert property (@(posedge clk) disable iff (!rst_n)
        so_o |=> !so_o);
    a_r4_pos_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (act && pos != '0) |-> (pos == $past(pos) + PW'(1)));
endmodule

// File: rtl/scan_sequencer.sv
// Module: scan_sequencer (top)
// Two chained token sections under one controller. Assumes si2_i is driven
// from so1_o so that the token crosses into section 2.
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int SEC_PIX   = DEF_SEC_PIX,
    parameter int RST_CLKS  = DEF_RST_CLKS,
    parameter int XFER_CLKS = DEF_XFER_CLKS,
    localparam int NSEC     = 2,
    localparam int PW       = $clog2(SEC_PIX),
    localparam int IW       = $clog2(NSEC * SEC_PIX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          si1_i,
    input  logic          si2_i,
    output logic          so1_o,
    output logic          so2_o,
    output logic          hold_o,
    output logic          integ_rst_o,
    output logic          oe1_o,
    output logic          oe2_o,
    output logic          pix_valid_o,
    output logic [IW-1:0] pix_idx_o,
    output logic          proto_err_o
);
    logic            launch;
    logic [NSEC-1:0] sec_start;
    logic [NSEC-1:0] sec_oe;
    logic [NSEC-1:0] sec_so;
    logic [PW-1:0]   sec_pos [NSEC];

    scan_ctrl #(
        .SEC_PIX  (SEC_PIX),
        .RST_CLKS (RST_CLKS),
        .XFER_CLKS(XFER_CLKS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .si_i       (si1_i),
        .launch_o   (launch),
        .hold_o     (hold_o),
        .integ_rst_o(integ_rst_o),
        .err_o      (proto_err_o)
    );

    assign sec_start = {si2_i, launch};

    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        scan_section #(.SEC_PIX(SEC_PIX)) sec_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(sec_start[g]),
            .oe_o   (sec_oe[g]),
            .so_o   (sec_so[g]),
            .pos_o  (sec_pos[g])
        );
    end

    // Purpose: map per-section state to pins and a global pixel index.
    assign oe1_o       = sec_oe[0];
    assign oe2_o       = sec_oe[1];
    assign so1_o       = sec_so[0];
    assign so2_o       = sec_so[1];
    assign pix_valid_o = |sec_oe;
    always_comb begin
        pix_idx_o = '0;
        if (sec_oe[0]) begin
            pix_idx_o = IW'(sec_pos[0]);
        end else if (sec_oe[1]) begin
            pix_idx_o = IW'(SEC_PIX) + IW'(sec_pos[1]);
        end
    end

    a_r5_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe1_o && oe2_o));
    a_r4_idx_increments: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid_o && $past(pix_valid_o)) |-> (pix_idx_o == $past(pix_idx_o) + IW'(1)));
    a_r10_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!oe1_o && !oe2_o && !proto_err_o && !hold_o));
endmodule

// File: tb/scan_sequencer_tb_top.sv
// Scoreboard bench: the driver task steps a timing model built from the
// requirements and queues one expected record per clock; the monitor pops
// and compares between edges.
module scan_sequencer_tb_top;
    localparam int SP  = 128;
    localparam int RC  = 18;
    localparam int XD  = 4;
    localparam int LEN = 2 * SP;
    localparam int IW  = $clog2(LEN);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic si1 = 1'b0;
    logic so1, so2, hold, irst, oe1, oe2, pv, err;
    logic [IW-1:0] idx;

    always #10 clk = ~clk;

    scan_sequencer #(.SEC_PIX(SP), .RST_CLKS(RC), .XFER_CLKS(XD)) dut_i (
        .clk(clk), .rst_n(rst_n), .si1_i(si1), .si2_i(so1),
        .so1_o(so1), .so2_o(so2), .hold_o(hold), .integ_rst_o(irst),
        .oe1_o(oe1), .oe2_o(oe2), .pix_valid_o(pv), .pix_idx_o(idx),
        .proto_err_o(err)
    );

    typedef struct {
        logic v; int idx; logic oe1, oe2, so1, so2, hold, irst, err;
    } exp_t;

    exp_t  q[$];
    exp_t  me;
    int    checks = 0, errors = 0, pk = 0, str_exp = 0, str_seen = 0;
    logic  m_err = 1'b0, m_prev = 1'b0;
    string phase = "R1";

    function automatic exp_t mk();
        exp_t e;
        e.v    = (pk >= 1 && pk <= LEN);
        e.idx  = e.v ? pk - 1 : 0;
        e.oe1  = (pk >= 1 && pk <= SP);
        e.oe2  = (pk > SP && pk <= LEN);
        e.so1  = (pk == SP);
        e.so2  = (pk == LEN);
        e.hold = (pk == 1);
        e.irst = (pk >= 1 && pk <= RC);
        e.err  = m_err;
        return e;
    endfunction

    task automatic cyc(input logic s);
        logic rise;
        @(negedge clk);
        rst_n = 1'b1;
        si1   = s;
        rise  = s && !m_prev;
        if (pk == 0) begin
            if (rise) pk = 1;
        end else begin
            if (rise) m_err = 1'b1;
            if (pk == LEN + XD) pk = 0;
            else pk++;
        end
        m_prev = s;
        q.push_back(mk());
        if (q[$].v) str_exp++;
    endtask

    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rst_n  = 1'b0;
            si1    = 1'b0;
            pk     = 0;
            m_err  = 1'b0;
            m_prev = 1'b0;
            q.push_back(mk());
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s (%s): got %0d expected %0d", tag, phase, act, exp);
        end
    endtask

    // Monitor: compare one queued record per clock, away from the edge.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            me = q.pop_front();
            checks++;
            if (pv) str_seen++;
            chk("R4 pix_valid", int'(pv), int'(me.v));
            chk("R4 pix_idx", int'(idx), me.idx);
            chk("R5 oe1", int'(oe1), int'(me.oe1));
            chk("R5 oe2", int'(oe2), int'(me.oe2));
            chk("R6 so1", int'(so1), int'(me.so1));
            chk("R6 so2", int'(so2), int'(me.so2));
            chk("R2 hold", int'(hold), int'(me.hold));
            chk("R3 integ_rst", int'(irst), int'(me.irst));
            chk("R8 proto_err", int'(err), int'(me.err));
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        phase = "R1";
        do_reset(3);
        repeat (3) cyc(1'b0);

        phase = "R2";
        cyc(1'b1);
        repeat (LEN + XD + 5) cyc(1'b0);

        phase = "R7";
        cyc(1'b1);
        repeat (LEN - 1 + XD) cyc(1'b0);
        cyc(1'b1);
        repeat (4) cyc(1'b0);

        phase = "R1";
        do_reset(2);
        repeat (2) cyc(1'b0);

        phase = "R7";
        cyc(1'b1);
        repeat (LEN + XD) cyc(1'b0);
        cyc(1'b1);
        repeat (LEN + XD + 3) cyc(1'b0);

        phase = "R10";
        cyc(1'b1);
        repeat (60) cyc(1'b0);
        do_reset(2);
        repeat (3) cyc(1'b0);
        cyc(1'b1);
        repeat (LEN + XD + 3) cyc(1'b0);

        phase = "R9";
        repeat (400) cyc(1'b1);
        repeat (10) cyc(1'b0);

        phase = "R8";
        cyc(1'b1);
        repeat (40) cyc(1'b0);
        cyc(1'b1);
        repeat (LEN + XD + 5) cyc(1'b0);

        repeat (3) @(posedge clk);
        #7;
        phase = "R4";
        checks++;
        chk("R4 strobe_total", str_seen, str_exp);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule